// File: doc/BRIEF.md
# Sixteen-Bit Multi-Function Arithmetic Logic Unit

This block is the purely combinational datapath core of a small load-store processor. Two 16-bit operands and a 4-bit function code go in, and one 16-bit word comes out in the same cycle. It has no condition flags. A comparison returns its outcome as an ordinary data word, 1 for true and 0 for false, which the processor can write to a register like any other result.

One adder works in two's complement and serves addition, subtraction and the three signed comparisons. Subtraction is formed as A + ~B + 1. Signed less-than takes the sign of the difference and XORs it with the signed overflow, so it stays correct across the whole signed range. One right-shifting barrel unit handles all three shifts: a left shift reverses the bit order before and after the unit. The shift distance is the low four bits of operand B.

Top module: `alu16`

## Requirements
- R1: Function code 0 (add) returns (A + B) mod 2^16.
- R2: Function code 1 (subtract) returns (A - B) mod 2^16.
- R3: Function code 4 (equal) returns 16'h0001 when A equals B and 16'h0000 otherwise.
- R4: Function code 5 (signed less-than) returns 16'h0001 when A < B as two's-complement numbers and 16'h0000 otherwise, including operand pairs whose difference overflows.
- R5: Function code 6 (signed less-or-equal) returns 16'h0001 when A <= B as two's-complement numbers and 16'h0000 otherwise.
- R6: Function codes 8, 9 and 10 return the bitwise AND, OR and XOR of A and B.
- R7: Function code 11 (identity) returns A unchanged for every value of B.
- R8: Function code 12 shifts A left by B[3:0] and fills with zeros. B[15:4] has no effect on the result.
- R9: Function code 13 shifts A right by B[3:0] and fills with zeros.
- R10: Function code 14 shifts A right by B[3:0] and fills with copies of A[15].
- R11: For codes 12, 13 and 14, a distance B[3:0] = 0 returns A unchanged.
- R12: Function codes 2, 3, 7 and 15 return 16'h0000.
- R13: Comparison results (codes 4, 5, 6) always have bits 15 to 1 equal to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_a | input | 16 | First operand; the value that is shifted or passed through |
| op_b | input | 16 | Second operand; its low four bits give the shift distance |
| func | input | 4 | Function code |
| result | output | 16 | Result word |

## Verification
Subtraction and signed comparison come from the same adder output in the same cycle. Where the two interact, the difference wraps while the comparison must not. The bench provokes this with corner operands such as 16'h8000 and 16'h7FFF paired in both orders, as well as 0, 1, -1 and powers of two. It judges the comparison against the bench's own signed-integer compare and the difference against plain modular arithmetic. A sweep over every shift distance with the upper bits of B set shows that one shifter serves three shift codes correctly.

// File: rtl/alu16.sv
module alu16 #(
  parameter int W = 16
) (
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  input  logic [3:0]   func,
  output logic [W-1:0] result
);
  localparam int SW = $clog2(W);

  localparam logic [3:0] F_ADD = 4'd0;
  localparam logic [3:0] F_SUB = 4'd1;
  localparam logic [3:0] F_EQ  = 4'd4;
  localparam logic [3:0] F_LT  = 4'd5;
  localparam logic [3:0] F_LE  = 4'd6;
  localparam logic [3:0] F_AND = 4'd8;
  localparam logic [3:0] F_OR  = 4'd9;
  localparam logic [3:0] F_XOR = 4'd10;
  localparam logic [3:0] F_ID  = 4'd11;
  localparam logic [3:0] F_SHL = 4'd12;
  localparam logic [3:0] F_SHR = 4'd13;
  localparam logic [3:0] F_SRA = 4'd14;

  logic          sub_mode;
  logic [W-1:0]  b_eff;
  logic [W-1:0]  sum;
  logic          ovf;
  logic          is_eq;
  logic          is_lt;

  assign sub_mode = (func != F_ADD);
  assign b_eff    = sub_mode ? ~op_b : op_b;
  assign sum      = op_a + b_eff + {{(W-1){1'b0}}, sub_mode};
  assign ovf      = (op_a[W-1] == b_eff[W-1]) && (sum[W-1] != op_a[W-1]);
  assign is_eq    = ~|sum;
  assign is_lt    = sum[W-1] ^ ovf;

  logic          shl;
  logic          fill;
  logic [SW-1:0] amt;
  logic [W-1:0]  a_rev;
  logic [W-1:0]  sh_in;
  logic [W-1:0]  sh_rev;
  logic [W-1:0]  sh_out;
  logic [W-1:0]  stage [0:SW];

  assign shl  = (func == F_SHL);
  assign fill = (func == F_SRA) & op_a[W-1];
  assign amt  = op_b[SW-1:0];

  for (genvar j = 0; j < W; j++) begin : g_rev
    assign a_rev[j]  = op_a[W-1-j];
    assign sh_rev[j] = stage[SW][W-1-j];
  end

  assign sh_in    = shl ? a_rev : op_a;
  assign stage[0] = sh_in;

  for (genvar i = 0; i < SW; i++) begin : g_stage
    localparam int D = 1 << i;
    assign stage[i+1] = amt[i] ? {{D{fill}}, stage[i][W-1:D]} : stage[i];
  end

  assign sh_out = shl ? sh_rev : stage[SW];

  always_comb begin
    case (func)
      F_ADD, F_SUB:  result = sum;
      F_EQ:          result = {{(W-1){1'b0}}, is_eq};
      F_LT:          result = {{(W-1){1'b0}}, is_lt};
      F_LE:          result = {{(W-1){1'b0}}, is_lt | is_eq};
      F_AND:         result = op_a & op_b;
      F_OR:          result = op_a | op_b;
      F_XOR:         result = op_a ^ op_b;
      F_ID:          result = op_a;
      F_SHL, F_SHR,
      F_SRA:         result = sh_out;
      default:       result = '0;
    endcase
  end
endmodule

// File: rtl/alu16_checks.sv
module alu16_checks #(
  parameter int W = 16
) (
  input logic [W-1:0] op_a,
  input logic [W-1:0] op_b,
  input logic [3:0]   func,
  input logic [W-1:0] result
);
  logic known;
  assign known = !$isunknown({op_a, op_b, func, result});

  always_comb begin
    if (known) begin
      if (func inside {4'd4, 4'd5, 4'd6})
        p_cmp_bool_r13: assert (result[W-1:1] == '0);
      if (func inside {4'd2, 4'd3, 4'd7, 4'd15})
        p_unused_zero_r12: assert (result == '0);
      if (func == 4'd11)
        p_identity_r7: assert (result == op_a);
      if (func inside {4'd12, 4'd13, 4'd14} && op_b[3:0] == 4'd0)
        p_shift_zero_r11: assert (result == op_a);
      if (func == 4'd4)
        p_eq_r3: assert (result[0] == (op_a == op_b));
      if (func == 4'd8)
        p_and_subset_r6: assert ((result & ~op_a) == '0 && (result & ~op_b) == '0);
      if (func == 4'd6 && result[0] == 1'b0)
        p_le_false_r5: assert (op_a != op_b);
      if (func == 4'd14 && op_a[W-1])
        p_sra_sign_r10: assert (result[W-1]);
    end
  end
endmodule

bind alu16 alu16_checks #(.W(W)) u_chk (.op_a(op_a), .op_b(op_b), .func(func), .result(result));

// File: tb/alu16_bench.sv
module alu16_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] op_a = '0;
  logic [15:0] op_b = '0;
  logic [3:0]  func = '0;
  logic [15:0] result;
  int          checks = 0;
  int          errors = 0;
  bit          done = 1'b0;

  always #10 clk = ~clk;

  alu16 u_alu16 (.op_a(op_a), .op_b(op_b), .func(func), .result(result));

  function automatic string tag(input logic [3:0] f, input logic [15:0] b);
    case (f)
      4'd0: return "R1";
      4'd1: return "R2";
      4'd4: return "R3/R13";
      4'd5: return "R4/R13";
      4'd6: return "R5/R13";
      4'd8, 4'd9, 4'd10: return "R6";
      4'd11: return "R7";
      4'd12: return (b[3:0] == 0) ? "R8/R11" : "R8";
      4'd13: return (b[3:0] == 0) ? "R9/R11" : "R9";
      4'd14: return (b[3:0] == 0) ? "R10/R11" : "R10";
      default: return "R12";
    endcase
  endfunction

  function automatic logic [15:0] model(input logic [3:0] f, input logic [15:0] a, input logic [15:0] b);
    int          sa, sb, n;
    logic [15:0] r;
    sa = $signed(a);
    sb = $signed(b);
    n  = b[3:0];
    case (f)
      4'd0: r = 16'((32'(a) + 32'(b)) % 65536);
      4'd1: r = 16'((32'(a) + 65536 - 32'(b)) % 65536);
      4'd4: r = (a == b) ? 16'd1 : 16'd0;
      4'd5: r = (sa < sb) ? 16'd1 : 16'd0;
      4'd6: r = (sa <= sb) ? 16'd1 : 16'd0;
      4'd8: r = a & b;
      4'd9: r = a | b;
      4'd10: r = a ^ b;
      4'd11: r = a;
      4'd12: r = 16'((32'(a) * (32'd1 << n)) % 65536);
      4'd13: r = 16'(32'(a) / (32'd1 << n));
      4'd14: begin
        if (sa >= 0) r = 16'(sa / (1 << n));
        else r = 16'(-((-sa + (1 << n) - 1) / (1 << n)));
      end
      default: r = 16'd0;
    endcase
    return r;
  endfunction

  task automatic check(input logic [3:0] f, input logic [15:0] a, input logic [15:0] b);
    logic [15:0] exp;
    @(negedge clk);
    func = f; op_a = a; op_b = b;
    #5;
    exp = model(f, a, b);
    checks++;
    if (result !== exp) begin
      errors++;
      $display("FAIL %s func=%0d a=%h b=%h actual=%h expected=%h", tag(f, b), f, a, b, result, exp);
    end
  endtask

  logic [15:0] corners [16];

  initial begin
    corners = '{16'h0000, 16'h0001, 16'hFFFF, 16'h8000, 16'h7FFF, 16'h8001, 16'h7FFE, 16'h0002,
                16'h00FF, 16'hFF00, 16'h5555, 16'hAAAA, 16'h1234, 16'hFFFE, 16'h4000, 16'h000F};
    repeat (3) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    checks++;
    if (result !== 16'h0000) begin
      errors++;
      $display("FAIL R1 reset-state actual=%h expected=0000", result);
    end
    for (int f = 0; f < 16; f++)
      for (int i = 0; i < 16; i++)
        for (int j = 0; j < 16; j++)
          check(4'(f), corners[i], corners[j]);
    for (int i = 0; i < 16; i++)
      for (int n = 0; n < 16; n++) begin
        check(4'd12, corners[i], 16'hFFF0 | 16'(n));
        check(4'd13, corners[i], 16'h0A50 | 16'(n));
        check(4'd14, corners[i], 16'h7770 | 16'(n));
      end
    for (int k = 0; k < 2000; k++) begin
      logic [15:0] ra, rb;
      ra = 16'($urandom);
      rb = 16'($urandom);
      for (int f = 0; f < 16; f++) check(4'(f), ra, rb);
      check(4'd5, ra, ra);
      check(4'd6, ra, ra);
      check(4'd4, ra, ra);
    end
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule